// File: doc/BRIEF.md
# Serial and Timer Interrupt Controller

This block collects interrupt sources for a sound and I/O peripheral and presents them to a CPU. It holds three registers. The interrupt enable register is five bits wide. The interrupt status register is also five bits wide. The serial status register records three receive errors and a pending transmit byte. The block drives one active-low interrupt request, and `irq_n` is low whenever any status bit is set.

The CPU reaches the block through a write port. That port decodes four strobes: error-clear, transmit data, interrupt enable and serial control. A combinational read port returns the inverted interrupt status and the serial status. Timer channels 1, 2 and 4 deliver one-cycle expiry pulses. The external receiver reports frame, overrun and keyboard errors as pulses.

Software acknowledges a source by rewriting the enable register with that bit at 0. The transmit-complete flag is raised only inside an enable write, and only when that write enables it, a byte is pending and transmit-ready status is clear.

Top module: `irq_serial_ctrl`

## Requirements
- R1: After reset, the enable, interrupt status, serial status and serial control registers are all 0 and `irq_n` is 1.
- R2: A write to the error-clear address (`A_ERR_CLR`, default 0) clears serial status bits 2:0. Bit 0 is frame error, bit 1 is overrun and bit 2 is keyboard error. Bit 3 is left unchanged.
- R3: A write to the transmit-data address (`A_TX_DATA`, default 1) sets the pending bit, which is serial status bit 3. If enable bit 4 is 1, the write also sets interrupt status bit 4 (transmit ready).
- R4: An enable write clears the pending bit and sets status bit 3 (transmit complete) only when all three of these hold: status bit 4 is 0 before the write, written bit 3 is 1, and the pending bit is 1.
- R5: An enable write (`A_IRQ_EN`, default 2) ANDs the interrupt status with written bits 4:0. Those bits then become the enable register.
- R6: A pulse on `tmr_expire[i]` sets status bit i only while enable bit i is 1. Bit 0 is timer 1, bit 1 is timer 2 and bit 2 is timer 4.
- R7: A serial-control write (`A_SER_CTL`, default 3) whose value equals the stored serial-control value changes nothing.
- R8: A serial-control write of a different value with bit 0 at 0 does four things: it clears the enable register, it clears the interrupt status, it clears serial status bits 2:0, and it keeps the pending bit.
- R9: `irq_n` is 0 exactly when at least one interrupt status bit is 1.
- R10: Reading `R_IRQ_ST` (default 2) returns the inverted status, with bits 7:5 read as 1. Reading `R_SER_ST` (default 3) returns {4'b0, pending, keyboard, overrun, frame}. Any other address reads 0. A pulse on `err_set[i]` sets serial status bit i.
- R11: A write takes effect on the rising clock edge that samples the strobe, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational |
| tmr_expire | input | 3 | Expiry pulses from timers 1, 2 and 4 |
| err_set | input | 3 | Receive error pulses: frame, overrun, keyboard |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its default parameters: a 3-bit address and the four write strobes at addresses 0 to 3. Read addresses 2 and 3 expose the status registers, so every register is observable through its read port or through `irq_n`. The enable register has no read port. It is observed by whether a later timer pulse raises its status bit. With these settings, directed sequences reach the cases where the transmit-complete flag must not be raised, the cases where a serial-control write must be ignored, and the case where one enable write both sets and masks status bits.

// File: rtl/irq_serial_ctrl.sv
module irq_serial_ctrl #(
  parameter int ADDR_W    = 3,
  parameter int A_ERR_CLR = 0,
  parameter int A_TX_DATA = 1,
  parameter int A_IRQ_EN  = 2,
  parameter int A_SER_CTL = 3,
  parameter int R_IRQ_ST  = 2,
  parameter int R_SER_ST  = 3,
  parameter int RUN_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [2:0]        tmr_expire,
  input  logic [2:0]        err_set,
  output logic              irq_n
);
  localparam int TXC = 3;
  localparam int TXR = 4;

  logic [4:0] en_q, en_d;
  logic [4:0] st_q, st_d;
  logic [2:0] err_q, err_d;
  logic       pend_q, pend_d;
  logic [7:0] ctl_q, ctl_d;

  always_comb begin
    en_d   = en_q;
    st_d   = st_q | {2'b00, tmr_expire & en_q[2:0]};
    err_d  = err_q | err_set;
    pend_d = pend_q;
    ctl_d  = ctl_q;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(A_ERR_CLR)) begin
        err_d = err_set;
      end else if (wr_addr == ADDR_W'(A_TX_DATA)) begin
        pend_d = 1'b1;
        if (en_q[TXR]) st_d[TXR] = 1'b1;
      end else if (wr_addr == ADDR_W'(A_IRQ_EN)) begin
        if (!st_q[TXR] && wr_data[TXC] && pend_q) begin
          pend_d    = 1'b0;
          st_d[TXC] = 1'b1;
        end
        st_d = st_d & wr_data[4:0];
        en_d = wr_data[4:0];
      end else if (wr_addr == ADDR_W'(A_SER_CTL)) begin
        if (wr_data != ctl_q) begin
          ctl_d = wr_data;
          if (!wr_data[RUN_BIT]) begin
            en_d  = '0;
            st_d  = '0;
            err_d = err_set;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      st_q   <= '0;
      err_q  <= '0;
      pend_q <= 1'b0;
      ctl_q  <= '0;
    end else begin
      en_q   <= en_d;
      st_q   <= st_d;
      err_q  <= err_d;
      pend_q <= pend_d;
      ctl_q  <= ctl_d;
    end
  end

  assign irq_n   = ~|st_q;
  assign rd_data = (rd_addr == ADDR_W'(R_IRQ_ST)) ? ~{3'b000, st_q} :
                   (rd_addr == ADDR_W'(R_SER_ST)) ? {4'b0000, pend_q, err_q} :
                   8'h00;
endmodule

module irq_serial_ctrl_chk #(
  parameter int ADDR_W    = 3,
  parameter int A_ERR_CLR = 0,
  parameter int A_TX_DATA = 1,
  parameter int A_IRQ_EN  = 2,
  parameter int A_SER_CTL = 3,
  parameter int R_IRQ_ST  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [2:0]        tmr_expire,
  input logic [2:0]        err_set,
  input logic              irq_n,
  input logic [4:0]        en_q,
  input logic [4:0]        st_q,
  input logic [2:0]        err_q,
  input logic              pend_q,
  input logic [7:0]        ctl_q
);
  // R9
  irq_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(R_IRQ_ST)) |-> (irq_n == (rd_data[4:0] == 5'h1f)));

  // R2
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_ERR_CLR) && err_set == 3'b000) |=> (err_q == 3'b000));

  // R3
  tx_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_TX_DATA)) |=> pend_q);

  // R5
  enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_IRQ_EN)) |=>
      ((st_q & ~$past(wr_data[4:0])) == 5'h00 && en_q == $past(wr_data[4:0])));

  // R6
  timer_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tmr_expire[0] && !en_q[0]) |=> (st_q[0] == $past(st_q[0])));

  // R7
  ctl_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(A_SER_CTL) && wr_data == ctl_q && tmr_expire == 3'b000) |=>
      ($stable(en_q) && $stable(st_q) && $stable(ctl_q)));
endmodule

bind irq_serial_ctrl irq_serial_ctrl_chk #(
  .ADDR_W(ADDR_W), .A_ERR_CLR(A_ERR_CLR), .A_TX_DATA(A_TX_DATA),
  .A_IRQ_EN(A_IRQ_EN), .A_SER_CTL(A_SER_CTL), .R_IRQ_ST(R_IRQ_ST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .tmr_expire(tmr_expire), .err_set(err_set),
  .irq_n(irq_n), .en_q(en_q), .st_q(st_q), .err_q(err_q), .pend_q(pend_q), .ctl_q(ctl_q)
);

// File: tb/sim_irq_serial_ctrl.sv
module sim_irq_serial_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] tmr_expire = '0;
  logic [2:0] err_set = '0;
  logic       irq_n;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_serial_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_expire(tmr_expire), .err_set(err_set),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tmr(input logic [2:0] t);
    @(negedge clk); tmr_expire = t;
    @(negedge clk); tmr_expire = '0;
  endtask

  task automatic pulse_err(input logic [2:0] e);
    @(negedge clk); err_set = e;
    @(negedge clk); err_set = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd2, v); chk("R1 irq status", v, 8'hff);
    rd(3'd3, v); chk("R1 serial status", v, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    rd(3'd5, v); chk("R10 unmapped read", v, 8'h00);
    pulse_tmr(3'b111);
    rd(3'd2, v); chk("R6 timers masked after reset", v, 8'hff);
  endtask

  task automatic t_timers();
    logic [7:0] v;
    wr(3'd3, 8'h01);
    wr(3'd2, 8'h01);
    pulse_tmr(3'b111);
    rd(3'd2, v); chk("R6 only timer1 enabled", v, 8'hfe);
    chk("R9 irq_n low", {7'd0, irq_n}, 8'h00);
    wr(3'd2, 8'h07);
    pulse_tmr(3'b110);
    rd(3'd2, v); chk("R6 all timers", v, 8'hf8);
    wr(3'd2, 8'h05);
    rd(3'd2, v); chk("R5 ack timer2 by mask", v, 8'hfa);
    wr(3'd2, 8'h04);
    rd(3'd2, v); chk("R5 ack timer1 by mask", v, 8'hfb);
    wr(3'd2, 8'h00);
    rd(3'd2, v); chk("R5 ack all", v, 8'hff);
    chk("R9 irq_n high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_tx_complete();
    logic [7:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h5a;
    rd(3'd3, v); chk("R11 not before edge", v, 8'h00);
    @(negedge clk); wr_en = 1'b0;
    rd(3'd3, v); chk("R3 pending set", v, 8'h08);
    rd(3'd2, v); chk("R3 ready masked", v, 8'hff);
    wr(3'd2, 8'h01);
    rd(3'd3, v); chk("R4 no complete without enable bit", v, 8'h08);
    wr(3'd2, 8'h08);
    rd(3'd2, v); chk("R4 complete set", v, 8'hf7);
    rd(3'd3, v); chk("R4 pending cleared", v, 8'h00);
    wr(3'd2, 8'h08);
    rd(3'd2, v); chk("R4 no pending no change", v, 8'hf7);
    wr(3'd2, 8'h00);
    rd(3'd2, v); chk("R5 complete acked", v, 8'hff);
  endtask

  task automatic t_tx_ready_blocks();
    logic [7:0] v;
    wr(3'd2, 8'h10);
    wr(3'd1, 8'h33);
    rd(3'd2, v); chk("R3 ready set", v, 8'hef);
    wr(3'd2, 8'h18);
    rd(3'd2, v); chk("R4 ready blocks complete", v, 8'hef);
    rd(3'd3, v); chk("R4 pending kept", v, 8'h08);
    wr(3'd2, 8'h08);
    rd(3'd2, v); chk("R4 ready still set at write", v, 8'hff);
    rd(3'd3, v); chk("R4 pending kept again", v, 8'h08);
    wr(3'd2, 8'h08);
    rd(3'd2, v); chk("R4 complete after ready clear", v, 8'hf7);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_errors();
    logic [7:0] v;
    wr(3'd1, 8'h00);
    pulse_err(3'b101);
    rd(3'd3, v); chk("R10 error bits", v, 8'h0d);
    pulse_err(3'b010);
    wr(3'd0, 8'h00);
    rd(3'd3, v); chk("R2 errors cleared pending kept", v, 8'h08);
  endtask

  task automatic t_ctl();
    logic [7:0] v;
    wr(3'd2, 8'h07);
    pulse_tmr(3'b001);
    wr(3'd3, 8'h01);
    pulse_tmr(3'b010);
    rd(3'd2, v); chk("R7 same ctl ignored", v, 8'hfc);
    pulse_err(3'b111);
    wr(3'd3, 8'h00);
    rd(3'd2, v); chk("R8 status cleared", v, 8'hff);
    chk("R8 irq_n high", {7'd0, irq_n}, 8'h01);
    rd(3'd3, v); chk("R8 errors cleared pending kept", v, 8'h08);
    pulse_tmr(3'b111);
    rd(3'd2, v); chk("R8 enable cleared", v, 8'hff);
    wr(3'd2, 8'h01);
    wr(3'd3, 8'h00);
    pulse_tmr(3'b001);
    rd(3'd2, v); chk("R7 repeated reset write ignored", v, 8'hfe);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timers();
    t_tx_complete();
    t_tx_ready_blocks();
    t_errors();
    t_ctl();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule